// File: doc/BRIEF.md
# Indirect Register Access Window

This block gives a host a narrow window onto a bank of internal 32-bit configuration registers. The host sees six directly mapped 16-bit registers: an address register, four data registers and a status register. Writing the address register launches one internal transaction. Bit 7 of the written value selects a read (1) or a write (0). Bits 6:1 name the internal register.

A write stores data register 1 as bits 31:16 and data register 0 as bits 15:0 of the named register. A read copies one 16-bit half into data register 0. Address bit 0 selects that half: 0 gives the lower half, 1 gives the upper half. Each transaction keeps a busy flag set for a fixed number of cycles, and software polls that flag before using the window again. Single-bit changes are done by software as a read, a local OR or AND-NOT, and then a full write.

The status register also carries two active-low reset controls for the internal device. The device runs only while both controls are 1.

Top module: `ira_window`

## Requirements
- R1: After the synchronous reset `rst`, every direct register reads zero. Status is therefore 0: not busy, no error, and the device held in reset.
- R2: An accepted address write sets status bit 0 (busy) for exactly LAT cycles (default 4), and the bit then reads 0. The transaction completes in the last of those cycles.
- R3: A transaction with address bit 7 = 0 stores {data1, data0} into internal register addr[6:1].
- R4: A transaction with address bit 7 = 1 loads data0 with bits 15:0 of register addr[6:1] when addr[0] = 0, and with bits 31:16 when addr[0] = 1. The load happens at completion.
- R5: An internal register that has not been written since its last clear reads zero.
- R6: While busy, a host write to the address register or to any data register is ignored and sets status bit 1 (error). The error bit stays set until any write to the status register.
- R7: Status bits 2 and 3 are the active-low reset controls. While they are not both 1, the following hold:
  - Address writes start nothing and change nothing.
  - A transaction in progress is abandoned and busy clears.
  - All internal registers are cleared to zero.
- R8: The contents of data registers 2 and 3 have no effect on the value stored by a write.
- R9: A write replaces both halves of the target register. All other internal registers are left unchanged.
- R10: A read transaction changes only data0. Data registers 1 to 3 and the address register keep their values.
- Host select encoding: 0 = address (reads back its low 8 bits), 1 to 4 = data0 to data3, 5 = status, 6 and 7 = none (they read 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 3 | Direct register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data of the selected register |

## Verification
A host write is taken at a clock edge, and the registered result shows on `host_rdata` from the following half cycle. Busy is high on the half-cycle samples after the launch edge and on the three samples that follow it. Busy reads 0 on the sample after the fourth edge, which is also when a read's data0 is due. The bench samples every expected value at a fixed point just after the falling edge and queues each expectation in the cycle it is due. A status write that holds the device clears busy one edge later, so the bench expects busy still set on the sample directly after that write and cleared on the next.

// File: rtl/ira_pkg.sv
`timescale 1ns/1ps
package ira_pkg;
    localparam int HW     = 16;   // host word width
    localparam int AW     = 8;    // address register width
    localparam int NDATA  = 4;    // data registers in the window
    localparam int IDXW   = 6;    // index bits carried in the address
    localparam int RD_BIT = 7;

    localparam int ST_BUSY = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_GRST = 2;
    localparam int ST_CRST = 3;

    typedef enum logic [2:0] {
        SEL_ADDR = 3'd0,
        SEL_D0   = 3'd1,
        SEL_D1   = 3'd2,
        SEL_D2   = 3'd3,
        SEL_D3   = 3'd4,
        SEL_STAT = 3'd5
    } win_sel_e;

    typedef struct packed {
        logic              rd;
        logic              upper;
        logic [IDXW-1:0]   idx;
        logic [2*HW-1:0]   wdata;
    } txn_t;

    function automatic logic [HW-1:0] pick_half(input logic [2*HW-1:0] w,
                                                input logic upper);
        return upper ? w[2*HW-1:HW] : w[HW-1:0];
    endfunction

    function automatic txn_t make_txn(input logic [AW-1:0] a,
                                      input logic [HW-1:0] lo,
                                      input logic [HW-1:0] hi);
        txn_t t;
        t.rd    = a[RD_BIT];
        t.upper = a[0];
        t.idx   = a[IDXW:1];
        t.wdata = {hi, lo};
        return t;
    endfunction
endpackage

// File: rtl/ira_host_regs.sv
`timescale 1ns/1ps
module ira_host_regs
    import ira_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            host_wr,
    input  logic [2:0]      host_sel,
    input  logic [HW-1:0]   host_wdata,
    output logic [HW-1:0]   host_rdata,
    input  logic            busy,
    input  logic            done,
    input  txn_t            cur,
    input  logic [2*HW-1:0] rd_word,
    output logic            launch,
    output txn_t            new_txn,
    output logic            hold,
    output logic            err,
    output logic [HW-1:0]   data1
);
    logic [AW-1:0] addr_q;
    logic [HW-1:0] data_q [NDATA];
    logic          grst_n, crst_n;

    assign hold    = !(grst_n && crst_n);
    assign launch  = host_wr && (host_sel == SEL_ADDR) && !busy && !hold;
    assign new_txn = make_txn(host_wdata[AW-1:0], data_q[0], data_q[1]);
    assign data1   = data_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            grst_n <= 1'b0;
            crst_n <= 1'b0;
            err    <= 1'b0;
            for (int i = 0; i < NDATA; i++) data_q[i] <= '0;
        end else begin
            if (host_wr) begin
                case (host_sel)
                    SEL_ADDR: begin
                        if (busy)       err    <= 1'b1;
                        else if (!hold) addr_q <= host_wdata[AW-1:0];
                    end
                    SEL_D0, SEL_D1, SEL_D2, SEL_D3: begin
                        if (busy) err <= 1'b1;
                        else      data_q[host_sel - 3'd1] <= host_wdata;
                    end
                    SEL_STAT: begin
                        grst_n <= host_wdata[ST_GRST];
                        crst_n <= host_wdata[ST_CRST];
                        err    <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (done && cur.rd)
                data_q[0] <= pick_half(rd_word, cur.upper);
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_sel)
            SEL_ADDR: host_rdata = {{(HW-AW){1'b0}}, addr_q};
            SEL_D0:   host_rdata = data_q[0];
            SEL_D1:   host_rdata = data_q[1];
            SEL_D2:   host_rdata = data_q[2];
            SEL_D3:   host_rdata = data_q[3];
            SEL_STAT: begin
                host_rdata[ST_BUSY] = busy;
                host_rdata[ST_ERR]  = err;
                host_rdata[ST_GRST] = grst_n;
                host_rdata[ST_CRST] = crst_n;
            end
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ira_sequencer.sv
`timescale 1ns/1ps
module ira_sequencer
    import ira_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic launch,
    input  txn_t new_txn,
    output logic busy,
    output logic done,
    output txn_t cur
);
    localparam int CNTW = $clog2(LAT + 1);
    logic [CNTW-1:0] cnt;

    assign done = busy && (cnt == CNTW'(1)) && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            cur  <= '0;
        end else if (hold) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (launch) begin
            busy <= 1'b1;
            cnt  <= CNTW'(LAT);
            cur  <= new_txn;
        end else if (busy) begin
            if (cnt == CNTW'(1)) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt - CNTW'(1);
            end
        end
    end
endmodule

// File: rtl/ira_reg_bank.sv
`timescale 1ns/1ps
module ira_reg_bank
    import ira_pkg::*;
#(
    parameter int NREG = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            wr_en,
    input  logic [IDXW-1:0] idx,
    input  logic [2*HW-1:0] wdata,
    output logic [2*HW-1:0] rd_word
);
    localparam int BW = (NREG > 1) ? $clog2(NREG) : 1;
    logic [2*HW-1:0] mem [NREG];
    logic [BW-1:0]   sel;

    assign sel     = BW'(idx);
    assign rd_word = mem[sel];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[sel] <= wdata;
        end
    end
endmodule

// File: rtl/ira_window.sv
`timescale 1ns/1ps
module ira_window
    import ira_pkg::*;
#(
    parameter int NREG = 64,
    parameter int LAT  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [2:0]    host_sel,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata
);
    logic            busy, done, launch, dev_hold, err;
    txn_t            new_txn, cur;
    logic [2*HW-1:0] rd_word;
    logic [HW-1:0]   dr1;
    logic            done_rd;

    assign done_rd = done && cur.rd;

    ira_host_regs u_regs (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .done(done), .cur(cur), .rd_word(rd_word),
        .launch(launch), .new_txn(new_txn), .hold(dev_hold),
        .err(err), .data1(dr1)
    );

    ira_sequencer #(.LAT(LAT)) u_seq (
        .clk(clk), .rst(rst), .hold(dev_hold),
        .launch(launch), .new_txn(new_txn),
        .busy(busy), .done(done), .cur(cur)
    );

    ira_reg_bank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst(rst), .clear(dev_hold),
        .wr_en(done && !cur.rd), .idx(cur.idx),
        .wdata(cur.wdata), .rd_word(rd_word)
    );
endmodule

// File: rtl/ira_window_chk.sv
`timescale 1ns/1ps
module ira_window_chk #(
    parameter int LAT = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        host_wr,
    input logic [2:0]  host_sel,
    input logic        busy,
    input logic        err,
    input logic        launch,
    input logic        done,
    input logic        hold,
    input logic        done_rd,
    input logic [15:0] dr1
);
    localparam int RW = $clog2(LAT + 1) + 1;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + RW'(1);
        else           run <= '0;
    end

    assert_launch_busy_R2: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);
    assert_busy_bound_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < RW'(LAT)));
    assert_done_timing_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (run == RW'(LAT - 1)));
    assert_err_set_R6: assert property (@(posedge clk) disable iff (rst)
        (host_wr && busy && host_sel <= 3'd4) |=> err);
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (err && !(host_wr && host_sel == 3'd5)) |=> err);
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        hold |=> !busy);
    assert_read_keeps_d1_R10: assert property (@(posedge clk) disable iff (rst)
        done_rd |=> $stable(dr1));
endmodule

bind ira_window ira_window_chk #(.LAT(LAT)) u_chk (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .busy(busy), .err(err), .launch(launch), .done(done),
    .hold(dev_hold), .done_rd(done_rd), .dr1(dr1)
);

// File: tb/ira_window_test.sv
`timescale 1ns/100ps
module ira_window_test;
    localparam logic [2:0] S_ADDR = 3'd0, S_D0 = 3'd1, S_D1 = 3'd2,
                           S_D2 = 3'd3, S_D3 = 3'd4, S_STAT = 3'd5;

    typedef struct {
        logic [2:0]  sel;
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ira_window uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    // monitor: pops queued expectations and compares them with the port
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if (host_rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h",
                             it.tag, it.sel, host_rdata, it.exp);
                end
            end
        end
    end

    task automatic hw(input logic [2:0] s, input logic [15:0] v);
        host_wr = 1'b1; host_sel = s; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic chk(input logic [2:0] s, input logic [15:0] e, input string tag);
        host_wr = 1'b0; host_sel = s;
        #0.5;
        q.push_back('{s, e, tag});
        @(negedge clk);
    endtask

    task automatic wait_idle();
        host_wr = 1'b0; host_sel = S_STAT;
        for (int k = 0; k < 50; k++) begin
            #0.5;
            if (host_rdata[0] == 1'b0) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic txn(input logic [7:0] a);
        hw(S_ADDR, {8'h00, a});
        wait_idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(S_ADDR, 16'h0000, "R1 addr");
        chk(S_D0,   16'h0000, "R1 data0");
        chk(S_D3,   16'h0000, "R1 data3");
        chk(S_STAT, 16'h0000, "R1 status");

        // R7 address write while held starts nothing
        hw(S_D0, 16'h1111);
        hw(S_ADDR, 16'h0004);
        chk(S_STAT, 16'h0000, "R7 no launch while held");
        chk(S_ADDR, 16'h0000, "R7 addr unchanged while held");
        hw(S_STAT, 16'h000C);
        chk(S_STAT, 16'h000C, "R7 released");

        // R5 unwritten register reads zero
        txn(8'h86);
        chk(S_D0, 16'h0000, "R5 unwritten reads zero");

        // R2 busy window, R3 write, R8 data2/3 ignored
        hw(S_D0, 16'h1234);
        hw(S_D1, 16'hABCD);
        hw(S_D2, 16'h5555);
        hw(S_D3, 16'hAAAA);
        hw(S_ADDR, 16'h0006);
        chk(S_STAT, 16'h000D, "R2 busy cycle 1");
        chk(S_STAT, 16'h000D, "R2 busy cycle 2");
        chk(S_STAT, 16'h000D, "R2 busy cycle 3");
        chk(S_STAT, 16'h000D, "R2 busy cycle 4");
        chk(S_STAT, 16'h000C, "R2 busy cleared");
        hw(S_D0, 16'h0000);
        txn(8'h86);
        chk(S_D0, 16'h1234, "R3 low half");
        txn(8'h87);
        chk(S_D0, 16'hABCD, "R4 upper half R8");
        chk(S_D1, 16'hABCD, "R10 data1 kept");
        chk(S_D3, 16'hAAAA, "R10 data3 kept");
        chk(S_ADDR, 16'h0087, "R10 addr kept");

        // R4 read result appears exactly at completion
        hw(S_ADDR, 16'h0086);
        chk(S_D0, 16'hABCD, "R4 data0 before completion");
        chk(S_D0, 16'hABCD, "R4 data0 before completion");
        chk(S_D0, 16'hABCD, "R4 data0 before completion");
        chk(S_D0, 16'hABCD, "R4 data0 before completion");
        chk(S_D0, 16'h1234, "R4 data0 at completion");

        // R6 writes while busy
        hw(S_ADDR, 16'h0087);
        hw(S_D0, 16'hFFFF);
        hw(S_ADDR, 16'h0010);
        chk(S_STAT, 16'h000F, "R6 busy and error");
        wait_idle();
        chk(S_STAT, 16'h000E, "R6 error sticky");
        chk(S_D0, 16'hABCD, "R6 data0 write ignored");
        chk(S_ADDR, 16'h0087, "R6 addr write ignored");
        hw(S_STAT, 16'h000C);
        chk(S_STAT, 16'h000C, "R6 error cleared");

        // R9 read-modify-write of one bit, full word replaced
        txn(8'h86);
        hw(S_D0, 16'h1234 | 16'h0100);
        hw(S_D1, 16'h0000);
        hw(S_D2, 16'h0000);
        hw(S_D3, 16'h0000);
        txn(8'h06);
        txn(8'h87);
        chk(S_D0, 16'h0000, "R9 upper half replaced");
        txn(8'h86);
        chk(S_D0, 16'h1334, "R9 bit set");

        // top index, neighbours untouched
        hw(S_D0, 16'hBEEF);
        hw(S_D1, 16'hCAFE);
        txn(8'h7E);
        txn(8'hFF);
        chk(S_D0, 16'hCAFE, "R3 top index upper");
        txn(8'h86);
        chk(S_D0, 16'h1334, "R9 other register unchanged");

        // R7 hold clears the bank
        hw(S_STAT, 16'h0000);
        chk(S_STAT, 16'h0000, "R7 held");
        hw(S_STAT, 16'h000C);
        txn(8'hFE);
        chk(S_D0, 16'h0000, "R7 bank cleared");

        // R7 hold abandons a transaction in progress
        hw(S_D0, 16'h7777);
        hw(S_D1, 16'h8888);
        hw(S_ADDR, 16'h0008);
        hw(S_STAT, 16'h0004);
        chk(S_STAT, 16'h0005, "R7 busy until next edge");
        chk(S_STAT, 16'h0004, "R7 busy abandoned");
        hw(S_STAT, 16'h000C);
        txn(8'h88);
        chk(S_D0, 16'h0000, "R7 abandoned write not stored");

        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule